// File: doc/BRIEF.md
# Per-Channel Soft Volume Ramp Controller

This block holds the attenuation of each audio channel of a multi-channel playback path and moves it toward a requested setting without audible clicks. Once per left/right clock period a sample strobe arrives together with one signed sample per channel. Each channel then has a target attenuation byte in whole decibels, a mute request, and a shared 2-bit transition policy. The block produces the present attenuation of every channel in 1/8 dB units and a flag that shows when the channel has reached the mute level. A later stage turns the attenuation into a linear gain and multiplies the samples. That stage is outside this block.

Four transition policies are available. A level change can be applied at once. It can wait for a zero crossing of that channel's own signal. It can slew in 1/8 dB steps with one step per sample period, which gives 1 dB every eight periods. Or it can slew with each step held until a zero crossing. In the two gated policies, a per-channel timeout forces the pending change through when the signal never crosses zero.

Each channel runs a small state machine with three states:
- `CH_SETTLED`: the level equals the target.
- `CH_ARMED`: a gated change or step is pending, and the timeout counter runs.
- `CH_SLEWING`: an ungated ramp is in progress.

All transitions are evaluated on strobe cycles only:
- settle: the new level equals the target, so the next state is `CH_SETTLED`.
- arm: a gated policy leaves a difference, so the next state is `CH_ARMED`. The counter restarts when a step is applied or when the machine enters the state from elsewhere.
- slew: an ungated ramp leaves a difference, so the next state is `CH_SLEWING`.

Top module: `soft_vol_ramp`

## Requirements
- R1: After reset every channel reports attenuation 0 and the muted flag low.
- R2: A volume byte b from 0 to 127 gives a target of 8*b units of 1/8 dB. A byte of 128 or more gives the mute level of 1024 units. The attenuation never exceeds 1024.
- R3: A mute request on a channel sets that channel's target to 1024. Releasing the request returns the target to the byte value. Both changes follow the selected policy.
- R4: In policy 2'b00, the level equals the target after a single strobe.
- R5: In policy 2'b01, the level jumps to the full target on the first strobe that has a zero crossing. A zero crossing is a sample whose sign bit differs from that of the channel's previous strobed sample, or a sample equal to zero. The previous sample counts as non-negative after reset.
- R6: In a gated policy, a pending change with no zero crossing is applied on the TIMEOUT_SAMPLES-th strobe after it became pending. The count restarts for every new step.
- R7: In policy 2'b10, the level moves one unit (1/8 dB) toward the target on each strobe and stops at the target.
- R8: In policy 2'b11, the level moves one unit toward the target on each strobe that has a zero crossing or a timeout, and holds on all other strobes.
- R9: Zero-crossing detection and level changes are independent per channel. Each channel uses only its own samples.
- R10: With gang_en high, every channel uses channel 0's volume byte and ignores its own byte. Mute requests stay per channel.
- R11: Attenuation and muted outputs change only on clock edges where sample_stb is high.
- R12: The muted flag of a channel is high exactly when its attenuation equals 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle strobe per sample period |
| sample_in | input | NUM_CH*SAMPLE_W | Signed samples, channel c at bits c*SAMPLE_W upward |
| vol_byte | input | NUM_CH*8 | Requested attenuation in dB per channel |
| mute_req | input | NUM_CH | Per-channel mute request |
| xfer_mode | input | 2 | Transition policy: 00 step, 01 zero cross, 10 slew, 11 slew on zero cross |
| gang_en | input | 1 | All channels follow channel 0's byte |
| atten_q8 | output | NUM_CH*11 | Present attenuation per channel in 1/8 dB units |
| muted | output | NUM_CH | Channel at mute level |

## Verification
The bench builds the block with three channels, 16-bit samples and TIMEOUT_SAMPLES set to 16. This lets both the 15-strobe hold and the 16th-strobe forced step of a gated change be reached in a few dozen cycles, and lets the restart of the count for each step be checked in a ramp gated on zero crossings. With three channels, one channel can see a sign change, a second a zero sample and a third a steady sign on the same strobe. Full ramps up to the 1024 mute level and back stay short enough to cover the muted flag in both directions.

// File: rtl/soft_vol_pkg.sv
package soft_vol_pkg;

    localparam int LVL_W    = 11;
    localparam int MUTE_LVL = 1024;

    typedef enum logic [1:0] {
        XM_STEP    = 2'b00,
        XM_ZCROSS  = 2'b01,
        XM_SLEW    = 2'b10,
        XM_SLEW_ZC = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        CH_SETTLED = 2'd0,
        CH_ARMED   = 2'd1,
        CH_SLEWING = 2'd2
    } ch_state_e;

    // whole-dB byte to 1/8 dB level; bytes past 127 or a mute map to the mute level
    function automatic logic [LVL_W-1:0] byte_to_level(input logic [7:0] b, input logic mute);
        if (mute || b[7])
            return LVL_W'(MUTE_LVL);
        return {1'b0, b[6:0], 3'b000};
    endfunction

endpackage

// File: rtl/vol_zc_detect.sv
module vol_zc_detect #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                zc
);

    logic prev_neg;

    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_neg <= 1'b0;
        else if (stb)
            prev_neg <= sample[SAMPLE_W-1];
    end

    always_comb begin
        zc = (sample == '0) || (sample[SAMPLE_W-1] != prev_neg);
    end

endmodule

// File: rtl/vol_target_sel.sv
module vol_target_sel
    import soft_vol_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH*8-1:0]     vol_byte,
    input  logic [NUM_CH-1:0]       mute_req,
    input  logic                    gang_en,
    output logic [NUM_CH*LVL_W-1:0] target
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [7:0] sel_byte;
        always_comb begin
            sel_byte = gang_en ? vol_byte[7:0] : vol_byte[c*8 +: 8];
            target[c*LVL_W +: LVL_W] = byte_to_level(sel_byte, mute_req[c]);
        end
    end

endmodule

// File: rtl/vol_chan_fsm.sv
module vol_chan_fsm
    import soft_vol_pkg::*;
#(
    parameter int TIMEOUT_SAMPLES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  xfer_mode_e       mode,
    input  logic [LVL_W-1:0] target,
    input  logic             zc,
    output logic [LVL_W-1:0] level,
    output logic             muted
);

    localparam int TMR_W = $clog2(TIMEOUT_SAMPLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_SAMPLES - 1);

    ch_state_e        state, state_nxt;
    logic [TMR_W-1:0] tmr, tmr_nxt, tmr_base;
    logic [LVL_W-1:0] lvl_nxt, cand, toward;
    logic             muted_nxt, gated, expire, differ, go;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CH_SETTLED;
            tmr   <= '0;
            level <= '0;
            muted <= 1'b0;
        end else begin
            state <= state_nxt;
            tmr   <= tmr_nxt;
            level <= lvl_nxt;
            muted <= muted_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        gated  = mode[0];
        differ = (level != target);
        toward = (target > level) ? level + LVL_W'(1) : level - LVL_W'(1);

        unique case (state)
            CH_ARMED:   tmr_base = tmr;
            CH_SETTLED: tmr_base = '0;
            CH_SLEWING: tmr_base = '0;
            default:    tmr_base = '0;
        endcase

        expire = (tmr_base == TMR_LAST);
        go     = !gated || zc || expire;

        unique case (mode)
            XM_STEP:    cand = target;
            XM_ZCROSS:  cand = target;
            XM_SLEW:    cand = toward;
            XM_SLEW_ZC: cand = toward;
            default:    cand = target;
        endcase

        lvl_nxt   = level;
        tmr_nxt   = tmr;
        state_nxt = state;
        muted_nxt = muted;

        if (stb) begin
            if (!differ) begin
                tmr_nxt = '0;
            end else if (go) begin
                lvl_nxt = cand;
                tmr_nxt = '0;
            end else begin
                tmr_nxt = tmr_base + TMR_W'(1);
            end

            if (lvl_nxt == target)
                state_nxt = CH_SETTLED;
            else if (gated)
                state_nxt = CH_ARMED;
            else
                state_nxt = CH_SLEWING;

            muted_nxt = (lvl_nxt == LVL_W'(MUTE_LVL));
        end
    end

endmodule

// File: rtl/soft_vol_ramp.sv
module soft_vol_ramp
    import soft_vol_pkg::*;
#(
    parameter int NUM_CH          = 8,
    parameter int SAMPLE_W        = 24,
    parameter int TIMEOUT_SAMPLES = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_stb,
    input  logic [NUM_CH*SAMPLE_W-1:0] sample_in,
    input  logic [NUM_CH*8-1:0]        vol_byte,
    input  logic [NUM_CH-1:0]          mute_req,
    input  logic [1:0]                 xfer_mode,
    input  logic                       gang_en,
    output logic [NUM_CH*LVL_W-1:0]    atten_q8,
    output logic [NUM_CH-1:0]          muted
);

    logic [NUM_CH*LVL_W-1:0] target;
    xfer_mode_e              mode;

    assign mode = xfer_mode_e'(xfer_mode);

    vol_target_sel #(.NUM_CH(NUM_CH)) u_target_sel (
        .vol_byte (vol_byte),
        .mute_req (mute_req),
        .gang_en  (gang_en),
        .target   (target)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic zc;

        vol_zc_detect #(.SAMPLE_W(SAMPLE_W)) u_zc (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (sample_stb),
            .sample (sample_in[c*SAMPLE_W +: SAMPLE_W]),
            .zc     (zc)
        );

        vol_chan_fsm #(.TIMEOUT_SAMPLES(TIMEOUT_SAMPLES)) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (sample_stb),
            .mode   (mode),
            .target (target[c*LVL_W +: LVL_W]),
            .zc     (zc),
            .level  (atten_q8[c*LVL_W +: LVL_W]),
            .muted  (muted[c])
        );
    end

endmodule

// File: rtl/soft_vol_ramp_chk.sv
module soft_vol_ramp_chk #(
    parameter int NUM_CH   = 8,
    parameter int LVL_W    = 11,
    parameter int MUTE_LVL = 1024
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sample_stb,
    input logic [1:0]              xfer_mode,
    input logic [NUM_CH*LVL_W-1:0] atten_q8,
    input logic [NUM_CH-1:0]       muted
);

    // R11
    idle_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(atten_q8));

    // R11
    idle_mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(muted));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [LVL_W-1:0] lv;
        assign lv = atten_q8[c*LVL_W +: LVL_W];

        // R2
        level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lv <= LVL_W'(MUTE_LVL));

        // R12
        mute_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            muted[c] == (lv == LVL_W'(MUTE_LVL)));

        // R7
        slew_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_stb && xfer_mode == 2'b10) |=>
            (lv == $past(lv) || lv == $past(lv) + LVL_W'(1) || lv == $past(lv) - LVL_W'(1)));

        // R8
        slew_zc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_stb && xfer_mode == 2'b11) |=>
            (lv == $past(lv) || lv == $past(lv) + LVL_W'(1) || lv == $past(lv) - LVL_W'(1)));
    end

endmodule

bind soft_vol_ramp soft_vol_ramp_chk #(.NUM_CH(NUM_CH)) u_soft_vol_ramp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .xfer_mode  (xfer_mode),
    .atten_q8   (atten_q8),
    .muted      (muted)
);

// File: tb/soft_vol_ramp_bench.sv
module soft_vol_ramp_bench;

    localparam int NCH = 3;
    localparam int SW  = 16;
    localparam int TMO = 16;
    localparam int LW  = 11;
    localparam int NV  = 19;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 stb = 1'b0;
    logic [1:0]           mode = 2'b00;
    logic                 gang = 1'b0;
    logic [NCH-1:0]       mreq = '0;
    logic [7:0]           vbyte [NCH];
    logic signed [SW-1:0] smp [NCH];
    logic [NCH*SW-1:0]    smp_flat;
    logic [NCH*8-1:0]     vb_flat;
    logic [NCH*LW-1:0]    atten;
    logic [NCH-1:0]       muted;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            smp_flat[c*SW +: SW] = smp[c];
            vb_flat[c*8 +: 8]    = vbyte[c];
        end
    end

    soft_vol_ramp #(.NUM_CH(NCH), .SAMPLE_W(SW), .TIMEOUT_SAMPLES(TMO)) u_soft_vol_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (stb),
        .sample_in  (smp_flat),
        .vol_byte   (vb_flat),
        .mute_req   (mreq),
        .xfer_mode  (mode),
        .gang_en    (gang),
        .atten_q8   (atten),
        .muted      (muted)
    );

    // {mode, byte, mute, alt, strobes, expected level, expected muted, req id}
    localparam logic [38:0] VEC [NV] = '{
        {2'd0, 8'd10,  1'b0, 1'b0, 11'd1,  11'd80,   1'b0, 4'd4},
        {2'd0, 8'd0,   1'b0, 1'b0, 11'd1,  11'd0,    1'b0, 4'd4},
        {2'd2, 8'd2,   1'b0, 1'b0, 11'd5,  11'd5,    1'b0, 4'd7},
        {2'd2, 8'd2,   1'b0, 1'b0, 11'd11, 11'd16,   1'b0, 4'd7},
        {2'd2, 8'd1,   1'b0, 1'b0, 11'd3,  11'd13,   1'b0, 4'd7},
        {2'd1, 8'd20,  1'b0, 1'b0, 11'd15, 11'd13,   1'b0, 4'd6},
        {2'd1, 8'd20,  1'b0, 1'b0, 11'd1,  11'd160,  1'b0, 4'd6},
        {2'd1, 8'd30,  1'b0, 1'b1, 11'd1,  11'd240,  1'b0, 4'd5},
        {2'd3, 8'd31,  1'b0, 1'b1, 11'd3,  11'd243,  1'b0, 4'd8},
        {2'd3, 8'd31,  1'b0, 1'b0, 11'd15, 11'd243,  1'b0, 4'd8},
        {2'd3, 8'd31,  1'b0, 1'b0, 11'd1,  11'd244,  1'b0, 4'd6},
        {2'd3, 8'd31,  1'b0, 1'b0, 11'd15, 11'd244,  1'b0, 4'd6},
        {2'd3, 8'd31,  1'b0, 1'b0, 11'd1,  11'd245,  1'b0, 4'd6},
        {2'd0, 8'd200, 1'b0, 1'b0, 11'd1,  11'd1024, 1'b1, 4'd2},
        {2'd0, 8'd127, 1'b0, 1'b0, 11'd1,  11'd1016, 1'b0, 4'd2},
        {2'd2, 8'd200, 1'b0, 1'b0, 11'd8,  11'd1024, 1'b1, 4'd12},
        {2'd2, 8'd127, 1'b0, 1'b0, 11'd1,  11'd1023, 1'b0, 4'd12},
        {2'd0, 8'd0,   1'b1, 1'b0, 11'd1,  11'd1024, 1'b1, 4'd3},
        {2'd2, 8'd126, 1'b0, 1'b0, 11'd3,  11'd1021, 1'b0, 4'd3}
    };

    function automatic string req_name(input logic [3:0] id);
        case (id)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R12";
        endcase
    endfunction

    function automatic int lvl_of(input int c);
        return int'(atten[c*LW +: LW]);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // alt: flip the sign (crossing); otherwise keep the sign (no crossing)
    task automatic set_pat(input int c, input bit alt);
        if (alt)
            smp[c] = (smp[c] < 0) ? SW'(100) : -SW'(100);
        else
            smp[c] = (smp[c] < 0) ? -SW'(100) : SW'(100);
    endtask

    task automatic strobe();
        @(negedge clk);
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [1:0]  v_mode;
        logic [7:0]  v_byte;
        logic        v_mute, v_alt, v_em;
        logic [10:0] v_n, v_el;
        logic [3:0]  v_req;

        for (int c = 0; c < NCH; c++) begin
            vbyte[c] = 8'd0;
            smp[c]   = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            check("R1", "reset level", lvl_of(c), 0);
            check("R1", "reset muted", int'(muted[c]), 0);
        end

        // vector table, all channels driven alike, channel 0 checked
        for (int v = 0; v < NV; v++) begin
            {v_mode, v_byte, v_mute, v_alt, v_n, v_el, v_em, v_req} = VEC[v];
            @(negedge clk);
            mode = v_mode;
            for (int c = 0; c < NCH; c++) begin
                vbyte[c] = v_byte;
                mreq[c]  = v_mute;
            end
            for (int k = 0; k < int'(v_n); k++) begin
                for (int c = 0; c < NCH; c++) set_pat(c, v_alt);
                strobe();
            end
            check(req_name(v_req), $sformatf("vector %0d level", v), lvl_of(0), int'(v_el));
            check(req_name(v_req), $sformatf("vector %0d muted", v), int'(muted[0]), int'(v_em));
        end

        // R11: no strobe, inputs changed, outputs unchanged
        @(negedge clk);
        mode = 2'b00;
        for (int c = 0; c < NCH; c++) vbyte[c] = 8'd0;
        mreq = '1;
        repeat (5) @(negedge clk);
        check("R11", "no-strobe level", lvl_of(1), 1021);
        check("R11", "no-strobe muted", int'(muted[1]), 0);
        mreq = '0;

        // R9 / R5: per-channel crossings
        strobe();
        check("R4", "step to zero", lvl_of(2), 0);
        @(negedge clk);
        mode = 2'b01;
        for (int c = 0; c < NCH; c++) vbyte[c] = 8'd10;
        set_pat(0, 1'b0);
        set_pat(1, 1'b1);
        smp[2] = '0;
        strobe();
        check("R9", "steady-sign channel held", lvl_of(0), 0);
        check("R9", "crossing channel moved", lvl_of(1), 80);
        check("R5", "zero sample counts as crossing", lvl_of(2), 80);

        // R10 gang, mute requests stay per channel
        @(negedge clk);
        mode     = 2'b00;
        gang     = 1'b1;
        vbyte[0] = 8'd5;
        vbyte[1] = 8'd90;
        vbyte[2] = 8'd40;
        mreq     = 3'b100;
        strobe();
        check("R10", "gang ch0", lvl_of(0), 40);
        check("R10", "gang ch1 ignores own byte", lvl_of(1), 40);
        check("R10", "gang ch2 own mute", lvl_of(2), 1024);
        check("R12", "ch2 muted flag", int'(muted[2]), 1);
        @(negedge clk);
        gang = 1'b0;
        strobe();
        check("R10", "ungang ch1 own byte", lvl_of(1), 720);
        check("R3", "ch2 still muted", lvl_of(2), 1024);
        check("R10", "ungang ch0", lvl_of(0), 40);

        finish_run();
    end

endmodule